// File: doc/BRIEF.md
# Overlay-Switched System Address Decoder

This block turns each access on a 24-bit byte-addressed processor bus into one registered decode result. The result holds a chip select for the attached device, the mirrored local address for RAM or ROM, and the register index for a peripheral. Decodable devices are RAM, ROM, two serial controllers, a floppy controller, a parallel interface adapter and a phase-read register. Accesses that decode to nothing raise a bus-error flag.

The lower half of the address space has two maps, and the overlay bit picks between them. The startup map places ROM at address zero so the processor can fetch its reset vectors. The normal map places RAM at address zero. The overlay bit is bit 4 of the interface adapter's port output. Each clock, a local register copies that bit. The register resets to 1, so the startup map is active after reset.

Memories smaller than their window repeat across it. The decoder does this by clearing the local-address bits above the memory size. The strobes are plain levels: an access is decoded in every cycle in which a strobe is high, and the result appears on the outputs one clock later. There is no valid/ready handshake on this block.

Top module: `sysdec_top`

## Requirements
- R1: The overlay register resets to 1 and then copies bit 4 of `gpio_pa` on every clock. An access uses the overlay value held before the edge that captures it. A value of 1 selects the startup map and 0 selects the normal map.
- R2: In the normal map, addresses 0x000000–0x3FFFFF select RAM (`sel` bit 0) with `mem_addr` equal to address bits [21:0].
- R3: In the normal map, addresses 0x400000–0x7FFFFF select ROM (`sel` bit 1) with `mem_addr` equal to address bits [19:0].
- R4: In the startup map, addresses 0x000000–0x5FFFFF select ROM (`sel` bit 1) with `mem_addr` equal to address bits [19:0].
- R5: In the startup map, addresses 0x600000–0x7FFFFF select RAM (`sel` bit 0) with `mem_addr` equal to address bits [20:0].
- R6: The following windows select a peripheral. Both strobes are treated alike:
  - 0x900000–0x9FFFFF selects serial controller 0 (`sel` bit 2).
  - 0xB00000–0xBFFFFF selects serial controller 1 (`sel` bit 3).
  - 0xD00000–0xDFFFFF selects the floppy controller (`sel` bit 4).
  - 0xE80000–0xEFFFFF selects the interface adapter (`sel` bit 5).
- R7: For a peripheral or phase-read select, `reg_idx` equals address bits [12:9] and `mem_addr` is 0. For a RAM or ROM select, `reg_idx` is 0.
- R8: 0xF00000–0xF7FFFF selects the phase-read register (`sel` bit 6). A read there also raises `phase_rvld` with `phase_rdata` = 0x00. A write there raises the select but not `phase_rvld`.
- R9: A read of 0xF80000–0xF8000F gives no select and no bus error. A write to that range raises `bus_err`.
- R10: Any other address with a strobe high raises `bus_err` and no select. Examples are 0x800000–0x8FFFFF, 0xA00000–0xAFFFFF, 0xC00000–0xCFFFFF, 0xE00000–0xE7FFFF and 0xF80010 upward.
- R11: Outputs are registered with one cycle of latency. A cycle with neither strobe high yields all-zero outputs. At most one `sel` bit is ever high, and none while `bus_err` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 24 | Byte address of the current access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| gpio_pa | input | 8 | Interface adapter port output; bit 4 is the overlay control |
| sel | output | 7 | One-hot device select (RAM, ROM, serial 0, serial 1, floppy, adapter, phase) |
| mem_addr | output | 23 | Mirrored local address for RAM or ROM |
| reg_idx | output | 4 | Peripheral register index |
| phase_rvld | output | 1 | Phase-read data valid |
| phase_rdata | output | 8 | Phase-read data (always 0x00) |
| bus_err | output | 1 | Unmapped access flag |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are never high in the same cycle. The property that flags a simultaneous read and write relies on this, and the stimulus raises at most one strobe per access. The assertions also assume that `gpio_pa` changes only between accesses. The stimulus holds both strobes low for a full cycle when it moves the overlay bit. Because of that idle cycle, the map an access uses is never in doubt.

// File: rtl/sysdec_pkg.sv
package sysdec_pkg;
  localparam int SEL_W   = 7;
  localparam int S_RAM   = 0;
  localparam int S_ROM   = 1;
  localparam int S_SER0  = 2;
  localparam int S_SER1  = 3;
  localparam int S_FLOP  = 4;
  localparam int S_ADPT  = 5;
  localparam int S_PHASE = 6;
  localparam int LADDR_W = 23;
  localparam int IDX_W   = 4;

  typedef struct packed {
    logic [SEL_W-1:0]   sel;
    logic [LADDR_W-1:0] laddr;
    logic [IDX_W-1:0]   idx;
    logic               rvld;
    logic               err;
  } dec_t;
endpackage

// File: rtl/sysdec_ovl_reg.sv
module sysdec_ovl_reg #(
  parameter int PORT_W  = 8,
  parameter int OVL_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] port_val,
  output logic              boot_map
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) boot_map <= 1'b1;
    else        boot_map <= port_val[OVL_BIT];
  end

  // R1
  ovl_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> boot_map == $past(port_val[OVL_BIT]));
endmodule

// File: rtl/sysdec_mem_map.sv
module sysdec_mem_map #(
  parameter int LADDR_W       = 23,
  parameter int RAM_NORM_BITS = 22,
  parameter int RAM_BOOT_BITS = 21,
  parameter int ROM_BITS      = 20
) (
  input  logic [LADDR_W-1:0] addr,
  input  logic               boot_map,
  output logic               is_ram,
  output logic               is_rom,
  output logic [LADDR_W-1:0] laddr
);
  localparam logic [LADDR_W-1:0] M_RAM_N = LADDR_W'((64'd1 << RAM_NORM_BITS) - 1);
  localparam logic [LADDR_W-1:0] M_RAM_B = LADDR_W'((64'd1 << RAM_BOOT_BITS) - 1);
  localparam logic [LADDR_W-1:0] M_ROM   = LADDR_W'((64'd1 << ROM_BITS) - 1);

  logic top_quarter;
  assign top_quarter = addr[LADDR_W-1] & addr[LADDR_W-2];

  always_comb begin
    if (boot_map) begin
      is_ram = top_quarter;
      is_rom = ~top_quarter;
      laddr  = addr & (top_quarter ? M_RAM_B : M_ROM);
    end else begin
      is_ram = ~addr[LADDR_W-1];
      is_rom = addr[LADDR_W-1];
      laddr  = addr & (addr[LADDR_W-1] ? M_ROM : M_RAM_N);
    end
  end
endmodule

// File: rtl/sysdec_io_map.sv
module sysdec_io_map #(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [4:0]        hit,
  output logic              quiet
);
  logic [3:0] nib;
  assign nib = addr[ADDR_W-1 -: 4];

  always_comb begin
    hit[0] = (nib == 4'h9);
    hit[1] = (nib == 4'hB);
    hit[2] = (nib == 4'hD);
    hit[3] = (nib == 4'hE) &  addr[ADDR_W-5];
    hit[4] = (nib == 4'hF) & ~addr[ADDR_W-5];
    quiet  = (nib == 4'hF) &  addr[ADDR_W-5] & (addr[ADDR_W-6:4] == '0);
  end
endmodule

// File: rtl/sysdec_top.sv
module sysdec_top
  import sysdec_pkg::*;
#(
  parameter int ADDR_W        = 24,
  parameter int PORT_W        = 8,
  parameter int OVL_BIT       = 4,
  parameter int IDX_LSB       = 9,
  parameter int RAM_NORM_BITS = 22,
  parameter int RAM_BOOT_BITS = 21,
  parameter int ROM_BITS      = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_rd,
  input  logic                 bus_wr,
  input  logic [PORT_W-1:0]    gpio_pa,
  output logic [SEL_W-1:0]     sel,
  output logic [LADDR_W-1:0]   mem_addr,
  output logic [IDX_W-1:0]     reg_idx,
  output logic                 phase_rvld,
  output logic [7:0]           phase_rdata,
  output logic                 bus_err
);
  logic               boot_map, is_ram, is_rom, quiet;
  logic [LADDR_W-1:0] m_laddr;
  logic [4:0]         io_hit;
  dec_t               dec_d, dec_q;

  sysdec_ovl_reg #(.PORT_W(PORT_W), .OVL_BIT(OVL_BIT)) ovl_i (
    .clk(clk), .rst_n(rst_n), .port_val(gpio_pa), .boot_map(boot_map));

  sysdec_mem_map #(.LADDR_W(LADDR_W), .RAM_NORM_BITS(RAM_NORM_BITS),
                   .RAM_BOOT_BITS(RAM_BOOT_BITS), .ROM_BITS(ROM_BITS)) mem_i (
    .addr(bus_addr[LADDR_W-1:0]), .boot_map(boot_map),
    .is_ram(is_ram), .is_rom(is_rom), .laddr(m_laddr));

  sysdec_io_map #(.ADDR_W(ADDR_W)) io_i (
    .addr(bus_addr), .hit(io_hit), .quiet(quiet));

  always_comb begin
    dec_d = '0;
    if (bus_rd | bus_wr) begin
      if (!bus_addr[ADDR_W-1]) begin
        dec_d.sel[S_RAM] = is_ram;
        dec_d.sel[S_ROM] = is_rom;
        dec_d.laddr      = m_laddr;
      end else if (|io_hit) begin
        dec_d.sel[S_PHASE:S_SER0] = io_hit;
        dec_d.idx  = bus_addr[IDX_LSB +: IDX_W];
        dec_d.rvld = io_hit[4] & bus_rd;
      end else if (!(quiet & bus_rd)) begin
        dec_d.err = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dec_q <= '0;
    else        dec_q <= dec_d;
  end

  assign sel         = dec_q.sel;
  assign mem_addr    = dec_q.laddr;
  assign reg_idx     = dec_q.idx;
  assign phase_rvld  = dec_q.rvld;
  assign phase_rdata = 8'h00;
  assign bus_err     = dec_q.err;

  // R11
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));
  // R11
  err_nosel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> sel == '0);
  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd | bus_wr) |=> (sel == '0 && !bus_err && !phase_rvld));
  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));
  // R3
  rom_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel[S_ROM] |-> mem_addr[LADDR_W-1:ROM_BITS] == '0);
  // R7
  idx_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd | bus_wr) && bus_addr[ADDR_W-1] |=>
      (sel == '0 || reg_idx == $past(bus_addr[IDX_LSB +: IDX_W])));
  // R8
  rvld_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_rvld |-> sel[S_PHASE] && $past(bus_rd));
endmodule

// File: tb/sysdec_top_tb_top.sv
module sysdec_top_tb_top;
  typedef struct packed {
    logic [6:0]  sel;
    logic [22:0] laddr;
    logic [3:0]  idx;
    logic        rvld;
    logic        err;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]  gpio_pa = 8'h10;
  logic [6:0]  sel;
  logic [22:0] mem_addr;
  logic [3:0]  reg_idx;
  logic        phase_rvld, bus_err;
  logic [7:0]  phase_rdata;

  int    n_run = 0, n_fail = 0;
  bit    boot = 1'b1, done = 1'b0;
  exp_t  exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  sysdec_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .gpio_pa(gpio_pa), .sel(sel), .mem_addr(mem_addr),
    .reg_idx(reg_idx), .phase_rvld(phase_rvld), .phase_rdata(phase_rdata),
    .bus_err(bus_err));

  function automatic exp_t model(input logic [23:0] a, input logic rd,
                                 input logic wr, input bit bm);
    exp_t e = '0;
    if (!(rd | wr)) return e;
    if (a < 24'h800000) begin
      if (!bm && a < 24'h400000)  begin e.sel = 7'h01; e.laddr = a[22:0] & 23'h3FFFFF; end
      else if (bm && a >= 24'h600000) begin e.sel = 7'h01; e.laddr = a[22:0] & 23'h1FFFFF; end
      else begin e.sel = 7'h02; e.laddr = a[22:0] & 23'h0FFFFF; end
    end else if (a >= 24'h900000 && a < 24'hA00000) begin e.sel = 7'h04; e.idx = a[12:9]; end
    else if (a >= 24'hB00000 && a < 24'hC00000) begin e.sel = 7'h08; e.idx = a[12:9]; end
    else if (a >= 24'hD00000 && a < 24'hE00000) begin e.sel = 7'h10; e.idx = a[12:9]; end
    else if (a >= 24'hE80000 && a < 24'hF00000) begin e.sel = 7'h20; e.idx = a[12:9]; end
    else if (a >= 24'hF00000 && a < 24'hF80000) begin
      e.sel = 7'h40; e.idx = a[12:9]; e.rvld = rd;
    end else if (a >= 24'hF80000 && a < 24'hF80010 && rd) begin
      e = '0;
    end else e.err = 1'b1;
    return e;
  endfunction

  task automatic access(input logic [23:0] a, input logic rd, input logic wr,
                        input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = rd; bus_wr = wr;
    exp_q.push_back(model(a, rd, wr, boot));
    tag_q.push_back(tag);
  endtask

  task automatic set_pa(input logic [7:0] v);
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0; gpio_pa = v; boot = v[4];
  endtask

  // monitor: pops one expectation right after each capturing edge
  initial begin
    forever begin
      @(posedge clk); #1;
      if (exp_q.size() > 0) begin
        exp_t e, act;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        act = '{sel: sel, laddr: mem_addr, idx: reg_idx, rvld: phase_rvld, err: bus_err};
        n_run++;
        if (act !== e || phase_rdata !== 8'h00) begin
          n_fail++;
          $display("FAIL %s: actual sel=%h addr=%h idx=%h rvld=%b err=%b rdata=%h expected sel=%h addr=%h idx=%h rvld=%b err=%b rdata=00",
                   t, act.sel, act.laddr, act.idx, act.rvld, act.err, phase_rdata,
                   e.sel, e.laddr, e.idx, e.rvld, e.err);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    gpio_pa = 8'h00; bus_addr = 24'h000040; bus_rd = 1'b1;
    repeat (3) @(negedge clk);
    n_run++;
    if (sel !== 7'h00 || bus_err !== 1'b0 || mem_addr !== '0) begin
      n_fail++;
      $display("FAIL R11 reset: actual sel=%h err=%b expected sel=00 err=0", sel, bus_err);
    end
    // R1: first capture after reset still uses startup map (reset value 1)
    rst_n = 1'b1;
    exp_q.push_back(model(24'h000040, 1'b1, 1'b0, 1'b1));
    tag_q.push_back("R1 reset startup map");
    boot = 1'b0;
    access(24'h000044, 1, 0, "R1 follows port bit normal");
    // normal map
    access(24'h000000, 1, 0, "R2 ram base");
    access(24'h3FFFFF, 0, 1, "R2 ram top");
    access(24'h400010, 1, 0, "R3 rom window 0x40");
    access(24'h7ABCDE, 1, 0, "R3 rom mirror 0x60");
    // peripherals
    access(24'h9FFE00, 1, 0, "R6 ser0 R7 idx");
    access(24'hB00200, 0, 1, "R6 ser1 R7 idx");
    access(24'hD01000, 1, 0, "R6 floppy R7 idx");
    access(24'hEFE1FF, 0, 1, "R6 adapter R7 idx");
    access(24'hF12345, 1, 0, "R8 phase read");
    access(24'hF7FFFF, 0, 1, "R8 phase write");
    access(24'hF80000, 1, 0, "R9 quiet read low");
    access(24'hF8000F, 1, 0, "R9 quiet read high");
    access(24'hF80004, 0, 1, "R9 quiet write err");
    access(24'hF80010, 1, 0, "R10 past quiet");
    access(24'h800000, 1, 0, "R10 gap 0x80");
    access(24'hA00000, 0, 1, "R10 gap 0xA0");
    access(24'hC12345, 1, 0, "R10 gap 0xC0");
    access(24'hE7FFFF, 1, 0, "R10 gap 0xE0");
    access(24'h9FFE00, 0, 0, "R11 idle zero");
    // back to startup map
    set_pa(8'h10);
    access(24'h000123, 1, 0, "R4 rom at zero");
    access(24'h1ABCDE, 1, 0, "R4 rom mirror 0x00");
    access(24'h5FFFFF, 0, 1, "R4 rom top 0x40");
    access(24'h600000, 1, 0, "R5 ram base");
    access(24'h7FFFFF, 0, 1, "R5 ram top");
    access(24'h3FFFFF, 1, 0, "R1 startup after set");
    set_pa(8'hEF);
    access(24'h600ABC, 1, 0, "R1 normal other bits set");
    @(negedge clk); bus_rd = 1'b0; bus_wr = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule